// File: doc/BRIEF.md
# GPIO Port with Peripheral Function Mux

This block is one port of general-purpose pins, sixteen by default, with a small register interface. Each pin is either driven by software through a data register and a direction register, or handed to one of four peripheral functions. A per-pin function-enable bit picks between the two owners. A per-pin 2-bit selector picks which peripheral owns the pin. Pads arrive as separate input, output and output-enable signals, so the pad cell itself stays outside the block.

Software changes single bits without a read-modify-write. The data register and the direction register each have a set alias and a clear alias that act only on the bits written as 1. An input-enable bit per pin gates the input path. When that bit is clear, the pin samples as 0 whatever the pad level. The sampled input passes through a synchroniser and goes to the peripherals. It is also returned when the data register is read, for pins configured as inputs.

Top module: `gpm_port`

## Requirements
- R1: While reset is asserted and after it is released, every register reads 0 and pad_oe and pad_out are 0: each pin is a GPIO input with its input buffer off.
- R2: A pin whose function-enable bit (address 0) is 1 takes pad_out and pad_oe from the selected peripheral: bit f*PINS+p of fn_dout and fn_doe. A pin whose bit is 0 is under GPIO control.
- R3: The peripheral number f for pin p is read from bits 2p+1:2p of the selector register (address 1, 32 bits wide).
- R4: Writing to the data-set alias (address 3) sets exactly the data bits written as 1. Writing to the data-clear alias (address 4) clears exactly those bits. All other data bits keep their value.
- R5: Writing to the direction-set alias (address 6) sets exactly the direction bits written as 1, making those pins outputs. Writing to the direction-clear alias (address 7) clears exactly those bits, making them inputs.
- R6: A write to address 2 replaces the whole data register, and a write to address 5 replaces the whole direction register.
- R7: A pin whose input-enable bit (address 8) is 0 samples as 0 on fn_din and on the data readback, whatever pad_in does.
- R8: Reading address 2 returns the data bit for pins whose direction bit is 1. For the other pins it returns the sampled pad input, which lags pad_in by SYNC_STAGES rising clock edges.
- R9: Under GPIO control, pad_oe equals the pin's direction bit and pad_out equals its data bit.
- R10: The other addresses read back what is stored there: 0 function enable, 1 selector, 5 direction, 8 input enable. The aliases (3, 4, 6, 7) and the unused addresses 9 to 15 read 0, and bits above the pin count read 0. Reads are combinational, and writes take effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for bus_addr |
| pad_in | input | PINS | Pad input levels |
| pad_out | output | PINS | Pad output levels |
| pad_oe | output | PINS | Pad output enables |
| fn_dout | input | NUM_FN*PINS | Peripheral outputs, peripheral f pin p at bit f*PINS+p |
| fn_doe | input | NUM_FN*PINS | Peripheral output enables, same layout |
| fn_din | output | PINS | Synchronised, input-enable-gated pad input for peripherals |

## Verification
Directed sequences come first. One uses set and clear patterns with overlapping ones, which separates a true bit-wise alias from a whole-register write. Another reads the data register with the input buffer off and then on, which separates gating from synchronisation lag. A third gives each pin a different function selector while the peripheral buses carry distinct values, which exposes any swapped or shifted selector field. A long random phase then mixes writes to every address with changing pads and peripheral buses. A behavioural model is compared against the design on every clock during that phase, so interactions between aliases, direction changes and the input delay are checked continuously.

// File: rtl/gpm_pkg.sv
`timescale 1ns/1ps
package gpm_pkg;
   localparam int ADDR_W = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_FUNC   = 4'd0,
      RA_SEL    = 4'd1,
      RA_DATA   = 4'd2,
      RA_DSET   = 4'd3,
      RA_DCLR   = 4'd4,
      RA_DIR    = 4'd5,
      RA_DIRSET = 4'd6,
      RA_DIRCLR = 4'd7,
      RA_INEN   = 4'd8
   } reg_addr_e;
endpackage

// File: rtl/gpm_regs.sv
`timescale 1ns/1ps
module gpm_regs
   import gpm_pkg::*;
#(
   parameter int PINS    = 16,
   parameter int FN_BITS = 2,
   parameter int DW      = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DW-1:0]             wdata,
   output logic [PINS-1:0]           fn_en_o,
   output logic [PINS*FN_BITS-1:0]   sel_o,
   output logic [PINS-1:0]           data_o,
   output logic [PINS-1:0]           dir_o,
   output logic [PINS-1:0]           inen_o
);
   localparam int SEL_W = PINS * FN_BITS;

   logic [PINS-1:0]  wbits;
   logic [SEL_W-1:0] wsel;

   assign wbits = wdata[PINS-1:0];
   assign wsel  = wdata[SEL_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fn_en_o <= '0;
         sel_o   <= '0;
         data_o  <= '0;
         dir_o   <= '0;
         inen_o  <= '0;
      end else if (we) begin
         case (addr)
            RA_FUNC:   fn_en_o <= wbits;
            RA_SEL:    sel_o   <= wsel;
            RA_DATA:   data_o  <= wbits;
            RA_DSET:   data_o  <= data_o | wbits;
            RA_DCLR:   data_o  <= data_o & ~wbits;
            RA_DIR:    dir_o   <= wbits;
            RA_DIRSET: dir_o   <= dir_o | wbits;
            RA_DIRCLR: dir_o   <= dir_o & ~wbits;
            RA_INEN:   inen_o  <= wbits;
            default:   ;
         endcase
      end
   end
endmodule

// File: rtl/gpm_sync.sv
`timescale 1ns/1ps
module gpm_sync #(
   parameter int W      = 16,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_chain
         logic [W-1:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= '0;
            end else begin
               st[0] <= d;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign q = st[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/gpm_pin_mux.sv
`timescale 1ns/1ps
module gpm_pin_mux #(
   parameter int FN_BITS = 2,
   localparam int NUM_FN = 1 << FN_BITS
) (
   input  logic               fn_en,
   input  logic [FN_BITS-1:0] sel,
   input  logic               gpio_out,
   input  logic               gpio_oe,
   input  logic [NUM_FN-1:0]  fn_out,
   input  logic [NUM_FN-1:0]  fn_oe,
   output logic               pad_out,
   output logic               pad_oe
);
   logic pick_out, pick_oe;

   assign pick_out = fn_out[sel];
   assign pick_oe  = fn_oe[sel];

   always_comb begin
      if (fn_en) begin
         pad_out = pick_out;
         pad_oe  = pick_oe;
      end else begin
         pad_out = gpio_out;
         pad_oe  = gpio_oe;
      end
   end
endmodule

// File: rtl/gpm_port.sv
`timescale 1ns/1ps
module gpm_port
   import gpm_pkg::*;
#(
   parameter int PINS        = 16,
   parameter int FN_BITS     = 2,
   parameter int DW          = 32,
   parameter int SYNC_STAGES = 2,
   localparam int NUM_FN     = 1 << FN_BITS
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_we,
   input  logic [3:0]             bus_addr,
   input  logic [DW-1:0]          bus_wdata,
   output logic [DW-1:0]          bus_rdata,
   input  logic [PINS-1:0]        pad_in,
   output logic [PINS-1:0]        pad_out,
   output logic [PINS-1:0]        pad_oe,
   input  logic [NUM_FN*PINS-1:0] fn_dout,
   input  logic [NUM_FN*PINS-1:0] fn_doe,
   output logic [PINS-1:0]        fn_din
);
   localparam int SEL_W = PINS * FN_BITS;

   generate
      if (SEL_W > DW) begin : g_bad_width
         $error("selector field does not fit the data width");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("at least one synchroniser stage is required");
      end
   endgenerate

   logic [PINS-1:0]  fn_en_q, data_q, dir_q, inen_q, sync_q, sampled;
   logic [SEL_W-1:0] sel_q;

   gpm_regs #(.PINS(PINS), .FN_BITS(FN_BITS), .DW(DW)) i_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (bus_we),
      .addr    (bus_addr),
      .wdata   (bus_wdata),
      .fn_en_o (fn_en_q),
      .sel_o   (sel_q),
      .data_o  (data_q),
      .dir_o   (dir_q),
      .inen_o  (inen_q)
   );

   gpm_sync #(.W(PINS), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (sync_q)
   );

   assign sampled = sync_q & inen_q;
   assign fn_din  = sampled;

   generate
      for (genvar p = 0; p < PINS; p++) begin : g_pin
         logic [NUM_FN-1:0] fo, fe;
         for (genvar f = 0; f < NUM_FN; f++) begin : g_fn
            assign fo[f] = fn_dout[f*PINS+p];
            assign fe[f] = fn_doe[f*PINS+p];
         end
         gpm_pin_mux #(.FN_BITS(FN_BITS)) i_mux (
            .fn_en    (fn_en_q[p]),
            .sel      (sel_q[p*FN_BITS +: FN_BITS]),
            .gpio_out (data_q[p]),
            .gpio_oe  (dir_q[p]),
            .fn_out   (fo),
            .fn_oe    (fe),
            .pad_out  (pad_out[p]),
            .pad_oe   (pad_oe[p])
         );
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         RA_FUNC: bus_rdata = DW'(fn_en_q);
         RA_SEL:  bus_rdata = DW'(sel_q);
         RA_DATA: bus_rdata = DW'((dir_q & data_q) | (~dir_q & sampled));
         RA_DIR:  bus_rdata = DW'(dir_q);
         RA_INEN: bus_rdata = DW'(inen_q);
         default: bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpm_port_chk.sv
`timescale 1ns/1ps
module gpm_port_chk
   import gpm_pkg::*;
#(
   parameter int PINS = 16,
   parameter int DW   = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            bus_we,
   input logic [3:0]      bus_addr,
   input logic [DW-1:0]   bus_wdata,
   input logic [DW-1:0]   bus_rdata,
   input logic [PINS-1:0] pad_oe,
   input logic [PINS-1:0] fn_en_q,
   input logic [PINS-1:0] data_q,
   input logic [PINS-1:0] dir_q,
   input logic [PINS-1:0] inen_q
);
   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |-> (pad_oe == '0)); // R1

   AST_DATA_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_DSET) |=>
      ((data_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0]))); // R4

   AST_DATA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_DCLR) |=>
      ((data_q & $past(bus_wdata[PINS-1:0])) == '0)); // R4

   AST_DIR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_DIRSET) |=>
      ((dir_q & $past(bus_wdata[PINS-1:0])) == $past(bus_wdata[PINS-1:0]))); // R5

   AST_DIR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == RA_DIRCLR) |=>
      ((dir_q & $past(bus_wdata[PINS-1:0])) == '0)); // R5

   AST_GATED_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == RA_DATA) |->
      ((bus_rdata[PINS-1:0] & ~dir_q & ~inen_q) == '0)); // R7

   AST_GPIO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      ((~fn_en_q & (pad_oe ^ dir_q)) == '0)); // R9
endmodule

bind gpm_port gpm_port_chk #(.PINS(PINS), .DW(DW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_oe    (pad_oe),
   .fn_en_q   (fn_en_q),
   .data_q    (data_q),
   .dir_q     (dir_q),
   .inen_q    (inen_q)
);

// File: tb/test_gpm_port.sv
`timescale 1ns/1ps
module test_gpm_port;
   localparam int PINS = 16;
   localparam int FNB  = 2;
   localparam int NFN  = 4;
   localparam int DW   = 32;
   localparam int SYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_we = 1'b0;
   logic [3:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [PINS-1:0] pad_in = '0;
   logic [PINS-1:0] pad_out, pad_oe, fn_din;
   logic [NFN*PINS-1:0] fn_dout = '0, fn_doe = '0;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   gpm_port #(.PINS(PINS), .FN_BITS(FNB), .DW(DW), .SYNC_STAGES(SYNC)) i_gpm_port (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .fn_dout(fn_dout), .fn_doe(fn_doe),
      .fn_din(fn_din));

   // behavioural reference model
   logic [15:0] m_fen = '0, m_data = '0, m_dir = '0, m_inen = '0;
   logic [31:0] m_sel = '0;
   logic [15:0] m_pipe[$] = '{16'h0, 16'h0};

   always @(posedge clk) begin
      if (!rst_n) begin
         m_fen = '0; m_data = '0; m_dir = '0; m_inen = '0; m_sel = '0;
         m_pipe = '{16'h0, 16'h0};
      end else begin
         if (bus_we) begin
            case (int'(bus_addr))
               0: m_fen  = bus_wdata[15:0];
               1: m_sel  = bus_wdata;
               2: m_data = bus_wdata[15:0];
               3: m_data = m_data | bus_wdata[15:0];
               4: m_data = m_data & ~bus_wdata[15:0];
               5: m_dir  = bus_wdata[15:0];
               6: m_dir  = m_dir | bus_wdata[15:0];
               7: m_dir  = m_dir & ~bus_wdata[15:0];
               8: m_inen = bus_wdata[15:0];
               default: ;
            endcase
         end
         m_pipe.push_back(pad_in);
         void'(m_pipe.pop_front());
      end
   end

   function automatic logic [15:0] m_sampled();
      return m_pipe[0] & m_inen;
   endfunction

   function automatic logic [31:0] m_read(input int a);
      case (a)
         0: return {16'h0, m_fen};
         1: return m_sel;
         2: return {16'h0, (m_dir & m_data) | (~m_dir & m_sampled())};
         5: return {16'h0, m_dir};
         8: return {16'h0, m_inen};
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_model();
      logic [15:0] e_out, e_oe;
      for (int p = 0; p < PINS; p++) begin
         if (m_fen[p]) begin
            int f;
            f = int'(m_sel[2*p +: 2]);
            e_out[p] = fn_dout[f*PINS+p];
            e_oe[p]  = fn_doe[f*PINS+p];
         end else begin
            e_out[p] = m_data[p];
            e_oe[p]  = m_dir[p];
         end
      end
      chk("R2 R3 R9 pad_out", 64'(pad_out), 64'(e_out));
      chk("R2 R3 R9 pad_oe", 64'(pad_oe), 64'(e_oe));
      chk("R7 fn_din", 64'(fn_din), 64'(m_sampled()));
      chk("R8 R10 rdata", 64'(bus_rdata), 64'(m_read(int'(bus_addr))));
   endtask

   task automatic cyc(input logic we, input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = we; bus_addr = a; bus_wdata = d;
      #1 compare_model();
   endtask

   task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
      @(negedge clk);
      bus_we = 1'b0; bus_addr = a;
      #1 chk(req, 64'(bus_rdata), 64'(exp));
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin : stim
      pad_in = 16'hFFFF;
      repeat (3) @(negedge clk);
      // R1: state under reset
      chk("R1 pad_oe", 64'(pad_oe), 64'h0);
      chk("R1 pad_out", 64'(pad_out), 64'h0);
      @(negedge clk) rst_n = 1'b1;
      for (int a = 0; a < 16; a++) rd(4'(a), 32'h0, "R1 reg read");

      // R4 R5 R9 set/clear aliases
      cyc(1, 4'd6, 32'h0000_00FF);
      cyc(1, 4'd3, 32'hFFFF_00A5);
      cyc(0, 4'd0, 32'h0);
      chk("R9 pad_oe", 64'(pad_oe), 64'h00FF);
      chk("R9 pad_out", 64'(pad_out), 64'h00A5);
      cyc(1, 4'd4, 32'h0000_0005);
      cyc(1, 4'd7, 32'h0000_000F);
      cyc(1, 4'd3, 32'h0000_0100);
      cyc(0, 4'd0, 32'h0);
      chk("R4 data alias", 64'(pad_out), 64'h01A0);
      rd(4'd5, 32'h0000_00F0, "R5 dir alias");
      rd(4'd3, 32'h0, "R10 alias reads zero");
      rd(4'd2, 32'h0000_00A0, "R7 R8 read input off");

      // R6 whole-register writes
      cyc(1, 4'd2, 32'hABCD_1234);
      cyc(1, 4'd5, 32'h0000_FFFF);
      cyc(0, 4'd0, 32'h0);
      chk("R6 data write", 64'(pad_out), 64'h1234);
      rd(4'd2, 32'h0000_1234, "R6 R8 output readback");

      // R7 R8 input gating and sync lag
      cyc(1, 4'd5, 32'h0000_FF00);
      pad_in = 16'h5A3C;
      repeat (4) cyc(0, 4'd2, 32'h0);
      rd(4'd2, 32'h0000_1200, "R7 input disabled");
      chk("R7 fn_din off", 64'(fn_din), 64'h0);
      cyc(1, 4'd8, 32'h0000_FFFF);
      cyc(0, 4'd2, 32'h0);
      rd(4'd2, 32'h0000_123C, "R8 input enabled");
      @(negedge clk) pad_in = 16'h00C3;
      #1 chk("R8 lag 0", 64'(fn_din), 64'h5A3C);
      @(negedge clk) #1 chk("R8 lag 1", 64'(fn_din), 64'h5A3C);
      @(negedge clk) #1 chk("R8 lag 2", 64'(fn_din), 64'h00C3);

      // R2 R3 peripheral selection with distinct buses
      fn_dout = {16'hF000, 16'h0F00, 16'h00F0, 16'h000F};
      fn_doe  = {16'h8888, 16'h4444, 16'h2222, 16'h1111};
      cyc(1, 4'd1, 32'hE4E4_1B1B);
      cyc(1, 4'd0, 32'h0000_F00F);
      cyc(0, 4'd1, 32'h0);
      chk("R3 selector read", 64'(bus_rdata), 64'hE4E4_1B1B);
      for (int k = 0; k < 20; k++) begin
         fn_dout = {$urandom, $urandom};
         fn_doe  = {$urandom, $urandom};
         cyc(0, 4'(k), 32'h0);
      end

      // random mix
      for (int k = 0; k < 600; k++) begin
         pad_in  = 16'($urandom);
         fn_dout = {$urandom, $urandom};
         fn_doe  = {$urandom, $urandom};
         cyc(1'($urandom), 4'($urandom_range(0, 12)), $urandom);
      end

      // R1 reset mid-run
      @(negedge clk) rst_n = 1'b0;
      #1 chk("R1 reset again", 64'(pad_oe), 64'h0);
      @(negedge clk) rst_n = 1'b1;
      rd(4'd0, 32'h0, "R1 func after reset");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule